// File: doc/BRIEF.md
# Layered Min-Sum Row Processor

This block handles one parity-check row of a layered LDPC decoder. For each variable connected to the row it receives two values: the current posterior LLR and the check-to-variable message that this row stored on the previous iteration. It subtracts the stored message from the posterior to get the extrinsic value. It then applies a min-sum update in one of three flavours: plain, offset (subtract beta and floor at zero) or normalized (scale by 3/4). Finally it returns the new posterior and the new message for each variable.

The schedule is serial and has two passes. In the collect pass, one variable arrives per clock, marked with first and last flags. The block buffers the extrinsic values and tracks four items: the smallest magnitude, the second-smallest magnitude, the position of the smallest, and the running XOR of the signs. In the emit pass, the results come out one per clock in arrival order. A hard decision goes with each result. On the final result, a done pulse carries a flag that says whether the row's parity is satisfied, so the surrounding decoder can stop early. Before the first iteration the caller must supply zero messages, so that the first pass works on the channel LLRs unchanged.

Top module: `minsum_row_proc`

## Requirements
- R1: After reset, `out_valid` and `row_done` are low until a row has been collected.
- R2: Each extrinsic value is the input posterior minus the input message. The result is saturated symmetrically to ±(2^(LLR_W-1)-1), which is ±127 at default widths.
- R3: With `mode` = 2'b00 (plain), each output message has two parts. Its sign is the XOR of the sign bits of every other extrinsic in the row, where zero counts as positive. Its magnitude is the minimum, over every other position, of that position's extrinsic magnitude clipped to 2^(MSG_W-1)-1 (31). A row of degree 1 gives magnitude 31.
- R4: With `mode` = 2'b01 (offset), the magnitude from R3 is reduced by `beta` and clamped at zero before the sign is applied.
- R5: With `mode` = 2'b10 (normalized), the magnitude from R3 becomes floor(3·m/4) before the sign is applied.
- R6: Each output posterior is the extrinsic plus the new message, saturated symmetrically to ±127.
- R7: Outputs appear one per clock, in input order, for exactly the row degree (up to MAX_DEG = 20). The first output comes on the cycle after the `in_last` input is accepted. `out_valid` then drops.
- R8: `out_hard` is 1 exactly when `out_post` is greater than zero.
- R9: `row_done` is high only together with the last output of a row. With it, `row_ok` is 1 when the XOR of that row's hard decisions is 0.
- R10: Input beats presented while outputs are being emitted are ignored and do not change the results.
- R11: `mode` = 2'b11 behaves like plain mode. `mode` and `beta` are sampled with the `in_last` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_first | input | 1 | Beat is the first variable of a row |
| in_last | input | 1 | Beat is the last variable of a row |
| in_post | input | LLR_W | Current posterior LLR, signed |
| in_msg | input | MSG_W | Stored check-to-variable message, signed |
| mode | input | 2 | Kernel select: 00 plain, 01 offset, 10 normalized, 11 plain |
| beta | input | BETA_W | Offset subtracted in offset mode |
| out_valid | output | 1 | Output beat valid |
| out_post | output | LLR_W | Updated posterior LLR, signed |
| out_msg | output | MSG_W | New check-to-variable message, signed |
| out_hard | output | 1 | Hard decision of the updated posterior |
| row_done | output | 1 | Pulses with the last output of a row |
| row_ok | output | 1 | Row parity satisfied, valid with `row_done` |

## Verification
The bench builds the block with its defaults: 8-bit LLRs, 6-bit messages, a 3-bit beta, a maximum degree of 20 and alpha of three quarters. With 6-bit messages, the clip at 31 is hit both by large extrinsic values and by degree-1 rows. With 8-bit LLRs, posteriors and messages can be chosen that drive both saturating adders to ±127. A full degree-20 row exercises the last buffer slot and the done timing at the counter's limit. The 3-bit beta reaches 7, which pushes small minima to zero.

// File: rtl/minsum_row_pkg.sv
package minsum_row_pkg;

   typedef enum logic [1:0] {
      KERN_PLAIN  = 2'b00,
      KERN_OFFSET = 2'b01,
      KERN_NORM   = 2'b10,
      KERN_ALT    = 2'b11
   } kern_mode_e;

   typedef enum logic {
      PH_COLLECT = 1'b0,
      PH_EMIT    = 1'b1
   } row_phase_e;

endpackage

// File: rtl/mr_sat_arith.sv
module mr_sat_arith #(
   parameter int A_W      = 8,
   parameter int B_W      = 6,
   parameter int O_W      = 8,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic signed [A_W-1:0] a,
   input  logic signed [B_W-1:0] b,
   output logic signed [O_W-1:0] y
);
   localparam int S_W  = A_W + 1;
   localparam int HI_I = (1 << (O_W - 1)) - 1;
   localparam logic signed [S_W-1:0] R_HI = S_W'(HI_I);
   localparam logic signed [S_W-1:0] R_LO = -R_HI;
   localparam logic signed [O_W-1:0] Y_HI = O_W'(HI_I);
   localparam logic signed [O_W-1:0] Y_LO = -Y_HI;

   if (B_W > A_W) begin : g_bad_b
      $error("mr_sat_arith: B_W must not exceed A_W");
   end
   if (O_W > A_W) begin : g_bad_o
      $error("mr_sat_arith: O_W must not exceed A_W");
   end

   logic signed [S_W-1:0] ax, bx, raw;
   assign ax = S_W'(a);
   assign bx = S_W'(b);

   if (SUBTRACT) begin : g_sub
      assign raw = ax - bx;
   end else begin : g_add
      assign raw = ax + bx;
   end

   always_comb begin
      if (raw > R_HI)      y = Y_HI;
      else if (raw < R_LO) y = Y_LO;
      else                 y = raw[O_W-1:0];
   end
endmodule

// File: rtl/mr_collect.sv
module mr_collect #(
   parameter int LLR_W   = 8,
   parameter int MSG_W   = 6,
   parameter int MAX_DEG = 20,
   localparam int MAG_W  = MSG_W - 1,
   localparam int IDX_W  = $clog2(MAX_DEG),
   localparam int DEG_W  = $clog2(MAX_DEG + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    accept,
   input  logic                    first,
   input  logic signed [LLR_W-1:0] post,
   input  logic signed [MSG_W-1:0] msg,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic signed [LLR_W-1:0] rd_ext,
   output logic [MAG_W-1:0]        min1,
   output logic [MAG_W-1:0]        min2,
   output logic [IDX_W-1:0]        min_idx,
   output logic                    sign_par,
   output logic [DEG_W-1:0]        degree
);
   localparam logic [MAG_W-1:0] MAG_MAX = '1;
   localparam int               MAG_MAX_I = (1 << MAG_W) - 1;

   logic signed [LLR_W-1:0] ext;
   logic [LLR_W-1:0]        ext_abs;
   logic [MAG_W-1:0]        mag;
   logic [DEG_W-1:0]        wr_pos;
   logic signed [LLR_W-1:0] buf_q [MAX_DEG];

   mr_sat_arith #(.A_W(LLR_W), .B_W(MSG_W), .O_W(LLR_W), .SUBTRACT(1'b1)) u_ext (
      .a(post), .b(msg), .y(ext)
   );

   assign ext_abs = ext[LLR_W-1] ? LLR_W'(-ext) : LLR_W'(ext);
   assign mag     = (ext_abs > LLR_W'(MAG_MAX_I)) ? MAG_MAX : ext_abs[MAG_W-1:0];
   assign wr_pos  = first ? '0 : degree;

   for (genvar g = 0; g < MAX_DEG; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    buf_q[g] <= '0;
         else if (accept && (wr_pos == DEG_W'(g)))      buf_q[g] <= ext;
      end
   end

   assign rd_ext = buf_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min1     <= MAG_MAX;
         min2     <= MAG_MAX;
         min_idx  <= '0;
         sign_par <= 1'b0;
         degree   <= '0;
      end else if (accept) begin
         if (first) begin
            min1     <= mag;
            min2     <= MAG_MAX;
            min_idx  <= '0;
            sign_par <= ext[LLR_W-1];
            degree   <= DEG_W'(1);
         end else if (degree < DEG_W'(MAX_DEG)) begin
            if (mag < min1) begin
               min2    <= min1;
               min1    <= mag;
               min_idx <= IDX_W'(wr_pos);
            end else if (mag < min2) begin
               min2 <= mag;
            end
            sign_par <= sign_par ^ ext[LLR_W-1];
            degree   <= degree + 1'b1;
         end
      end
   end

   // R2: the saturated extrinsic never reaches the most negative code
   a_r2_ext_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (ext != {1'b1, {(LLR_W-1){1'b0}}}));

   // R3: the two tracked minima stay ordered
   a_r3_min_order: assert property (@(posedge clk) disable iff (!rst_n)
      min1 <= min2);
endmodule

// File: rtl/mr_kernel.sv
module mr_kernel #(
   parameter int MSG_W   = 6,
   parameter int BETA_W  = 3,
   parameter int MAX_DEG = 20,
   parameter int ALPHA_Q = 3,
   localparam int MAG_W  = MSG_W - 1,
   localparam int IDX_W  = $clog2(MAX_DEG)
) (
   input  logic [1:0]              mode,
   input  logic [BETA_W-1:0]       beta,
   input  logic [IDX_W-1:0]        idx,
   input  logic [IDX_W-1:0]        min_idx,
   input  logic [MAG_W-1:0]        min1,
   input  logic [MAG_W-1:0]        min2,
   input  logic                    sign_par,
   input  logic                    self_sign,
   output logic signed [MSG_W-1:0] msg
);
   import minsum_row_pkg::*;

   if (BETA_W > MAG_W) begin : g_bad_beta
      $error("mr_kernel: BETA_W must not exceed message magnitude width");
   end
   if (ALPHA_Q < 1 || ALPHA_Q > 3) begin : g_bad_alpha
      $error("mr_kernel: ALPHA_Q must be 1, 2 or 3 quarters");
   end

   logic [MAG_W-1:0] m_sel, m_off, m_norm, m_res;
   logic [MAG_W-1:0] beta_x;
   logic             neg;

   assign m_sel  = (idx == min_idx) ? min2 : min1;
   assign beta_x = MAG_W'(beta);
   assign m_off  = (m_sel > beta_x) ? (m_sel - beta_x) : '0;

   if (ALPHA_Q == 3) begin : g_alpha_shift_add
      logic [MAG_W+1:0] tri_m;
      assign tri_m  = {2'b00, m_sel} + {1'b0, m_sel, 1'b0};
      assign m_norm = tri_m[MAG_W+1:2];
   end else begin : g_alpha_mult
      logic [MAG_W+1:0] prod;
      assign prod   = {2'b00, m_sel} * (MAG_W + 2)'(ALPHA_Q);
      assign m_norm = prod[MAG_W+1:2];
   end

   always_comb begin
      case (kern_mode_e'(mode))
         KERN_OFFSET: m_res = m_off;
         KERN_NORM:   m_res = m_norm;
         default:     m_res = m_sel;
      endcase
   end

   assign neg = sign_par ^ self_sign;
   assign msg = neg ? -$signed({1'b0, m_res}) : $signed({1'b0, m_res});
endmodule

// File: rtl/minsum_row_proc.sv
module minsum_row_proc #(
   parameter int LLR_W   = 8,
   parameter int MSG_W   = 6,
   parameter int BETA_W  = 3,
   parameter int MAX_DEG = 20,
   parameter int ALPHA_Q = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_first,
   input  logic                     in_last,
   input  logic signed [LLR_W-1:0]  in_post,
   input  logic signed [MSG_W-1:0]  in_msg,
   input  logic [1:0]               mode,
   input  logic [BETA_W-1:0]        beta,
   output logic                     out_valid,
   output logic signed [LLR_W-1:0]  out_post,
   output logic signed [MSG_W-1:0]  out_msg,
   output logic                     out_hard,
   output logic                     row_done,
   output logic                     row_ok
);
   import minsum_row_pkg::*;

   localparam int MAG_W = MSG_W - 1;
   localparam int IDX_W = $clog2(MAX_DEG);
   localparam int DEG_W = $clog2(MAX_DEG + 1);

   if (MAX_DEG < 2) begin : g_bad_deg
      $error("minsum_row_proc: MAX_DEG must be at least 2");
   end
   if (MSG_W < 2 || MSG_W >= LLR_W) begin : g_bad_width
      $error("minsum_row_proc: MSG_W must be at least 2 and below LLR_W");
   end

   row_phase_e              phase;
   logic                    accept;
   logic [IDX_W-1:0]        rd_idx;
   logic signed [LLR_W-1:0] rd_ext;
   logic [MAG_W-1:0]        min1, min2;
   logic [IDX_W-1:0]        min_idx;
   logic                    sign_par;
   logic [DEG_W-1:0]        degree;
   logic [1:0]              mode_q;
   logic [BETA_W-1:0]       beta_q;
   logic                    par_q;
   logic                    at_end;

   assign accept = in_valid && (phase == PH_COLLECT);

   mr_collect #(.LLR_W(LLR_W), .MSG_W(MSG_W), .MAX_DEG(MAX_DEG)) u_collect (
      .clk(clk), .rst_n(rst_n), .accept(accept), .first(in_first),
      .post(in_post), .msg(in_msg), .rd_idx(rd_idx), .rd_ext(rd_ext),
      .min1(min1), .min2(min2), .min_idx(min_idx), .sign_par(sign_par),
      .degree(degree)
   );

   mr_kernel #(.MSG_W(MSG_W), .BETA_W(BETA_W), .MAX_DEG(MAX_DEG), .ALPHA_Q(ALPHA_Q)) u_kernel (
      .mode(mode_q), .beta(beta_q), .idx(rd_idx), .min_idx(min_idx),
      .min1(min1), .min2(min2), .sign_par(sign_par),
      .self_sign(rd_ext[LLR_W-1]), .msg(out_msg)
   );

   mr_sat_arith #(.A_W(LLR_W), .B_W(MSG_W), .O_W(LLR_W), .SUBTRACT(1'b0)) u_post (
      .a(rd_ext), .b(out_msg), .y(out_post)
   );

   assign at_end = (DEG_W'(rd_idx) == degree - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_COLLECT;
         rd_idx <= '0;
         mode_q <= '0;
         beta_q <= '0;
         par_q  <= 1'b0;
      end else if (phase == PH_COLLECT) begin
         if (accept && in_last) begin
            phase  <= PH_EMIT;
            rd_idx <= '0;
            mode_q <= mode;
            beta_q <= beta;
            par_q  <= 1'b0;
         end
      end else begin
         par_q <= par_q ^ out_hard;
         if (at_end) phase <= PH_COLLECT;
         else        rd_idx <= rd_idx + 1'b1;
      end
   end

   assign out_valid = (phase == PH_EMIT);
   assign out_hard  = ~out_post[LLR_W-1] && (out_post != '0);
   assign row_done  = out_valid && at_end;
   assign row_ok    = row_done && !(par_q ^ out_hard);

   // R9: the done pulse is a single cycle wide
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      row_done |=> !row_done);

   // R7: the output run ends only through the done beat
   a_r7_run_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !row_done) |=> out_valid);

   // R6: the updated posterior stays inside the symmetric range
   a_r6_post_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_post != {1'b1, {(LLR_W-1){1'b0}}}));

   // R3: the new message never takes the most negative code
   a_r3_msg_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_msg != {1'b1, {(MSG_W-1){1'b0}}}));

   // R10: during emission the message minima do not move
   a_r10_hold_minima: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> ($stable(min1) && $stable(min2) && $stable(sign_par)));
endmodule

// File: tb/minsum_row_proc_bench.sv
module minsum_row_proc_bench;
   localparam int LLR_W = 8;
   localparam int MSG_W = 6;
   localparam int BETA_W = 3;
   localparam int MAX_DEG = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic signed [LLR_W-1:0] in_post = '0;
   logic signed [MSG_W-1:0] in_msg = '0;
   logic [1:0] mode = 2'b00;
   logic [BETA_W-1:0] beta = '0;
   logic out_valid, out_hard, row_done, row_ok;
   logic signed [LLR_W-1:0] out_post;
   logic signed [MSG_W-1:0] out_msg;

   int n_chk = 0;
   int n_bad = 0;
   int p_a [MAX_DEG];
   int m_a [MAX_DEG];

   always #10 clk = ~clk;

   minsum_row_proc u_minsum_row_proc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .in_post(in_post), .in_msg(in_msg), .mode(mode),
      .beta(beta), .out_valid(out_valid), .out_post(out_post),
      .out_msg(out_msg), .out_hard(out_hard), .row_done(row_done),
      .row_ok(row_ok)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int clampi(input int x, input int lim);
      if (x > lim) return lim;
      if (x < -lim) return -lim;
      return x;
   endfunction

   task automatic run_row(input int deg, input int md, input int bt, input string req, input bit poke);
      int ext [MAX_DEG];
      int mg [MAX_DEG];
      int em [MAX_DEG];
      int ep [MAX_DEG];
      int eh [MAX_DEG];
      int par;
      par = 0;
      for (int k = 0; k < deg; k++) begin
         ext[k] = clampi(p_a[k] - m_a[k], 127);
         mg[k]  = (ext[k] < 0) ? -ext[k] : ext[k];
         if (mg[k] > 31) mg[k] = 31;
      end
      for (int i = 0; i < deg; i++) begin
         int mn;
         int sg;
         mn = 31;
         sg = 0;
         for (int j = 0; j < deg; j++) begin
            if (j != i) begin
               if (mg[j] < mn) mn = mg[j];
               if (ext[j] < 0) sg ^= 1;
            end
         end
         if (md == 1) mn = (mn > bt) ? mn - bt : 0;
         else if (md == 2) mn = (3 * mn) / 4;
         em[i] = sg ? -mn : mn;
         ep[i] = clampi(ext[i] + em[i], 127);
         eh[i] = (ep[i] > 0) ? 1 : 0;
         par ^= eh[i];
      end
      for (int k = 0; k < deg; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_first = (k == 0);
         in_last  = (k == deg - 1);
         in_post  = LLR_W'(p_a[k]);
         in_msg   = MSG_W'(m_a[k]);
         mode     = md[1:0];
         beta     = BETA_W'(bt);
      end
      @(negedge clk);
      in_valid = poke;
      in_first = poke;
      in_last  = poke;
      in_post  = poke ? -LLR_W'(100) : '0;
      in_msg   = poke ? MSG_W'(25) : '0;
      if (poke) begin mode = 2'b01; beta = '1; end
      for (int i = 0; i < deg; i++) begin
         check(req, "out_valid", int'(out_valid), 1);
         check(req, "out_msg", int'(out_msg), em[i]);
         check(req, "out_post", int'(out_post), ep[i]);
         check("R8", "out_hard", int'(out_hard), eh[i]);
         check("R9", "row_done", int'(row_done), (i == deg - 1) ? 1 : 0);
         if (i == deg - 1) check("R9", "row_ok", int'(row_ok), (par == 0) ? 1 : 0);
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_first = 1'b0;
      in_last  = 1'b0;
      check("R7", "out_valid after run", int'(out_valid), 0);
      check("R7", "row_done after run", int'(row_done), 0);
   endtask

   task automatic fill(input int deg, input int seed);
      for (int k = 0; k < deg; k++) begin
         p_a[k] = ((k * 37 + seed * 11) % 255) - 127;
         m_a[k] = ((k * 13 + seed * 7) % 63) - 31;
      end
   endtask

   task automatic t_reset;
      // R1: idle outputs after reset
      check("R1", "out_valid at reset", int'(out_valid), 0);
      check("R1", "row_done at reset", int'(row_done), 0);
   endtask

   task automatic t_plain;
      // R3 R2 R6: plain kernel on two patterns, first-pass zero messages too
      fill(6, 1);
      run_row(6, 0, 0, "R3", 1'b0);
      for (int k = 0; k < 5; k++) begin p_a[k] = (k % 2 == 0) ? 9 + k : -4 - k; m_a[k] = 0; end
      run_row(5, 0, 0, "R2", 1'b0);
   endtask

   task automatic t_ties;
      // R3: equal minima and degree 1 clip
      p_a[0] = 5; p_a[1] = -5; p_a[2] = 40; p_a[3] = 5;
      for (int k = 0; k < 4; k++) m_a[k] = 0;
      run_row(4, 0, 0, "R3", 1'b0);
      p_a[0] = -60; m_a[0] = 0;
      run_row(1, 0, 0, "R3", 1'b0);
   endtask

   task automatic t_offset;
      // R4: offset with clamp to zero
      fill(7, 3);
      run_row(7, 1, 3, "R4", 1'b0);
      for (int k = 0; k < 4; k++) begin p_a[k] = 3 + k * 2; m_a[k] = 0; end
      run_row(4, 1, 7, "R4", 1'b0);
   endtask

   task automatic t_norm;
      // R5: normalized by three quarters
      fill(8, 5);
      run_row(8, 2, 0, "R5", 1'b0);
      for (int k = 0; k < 3; k++) begin p_a[k] = 30 - k; m_a[k] = 0; end
      run_row(3, 2, 0, "R5", 1'b0);
   endtask

   task automatic t_alt_mode;
      // R11: mode 11 follows plain, beta ignored
      fill(5, 7);
      run_row(5, 3, 5, "R11", 1'b0);
   endtask

   task automatic t_saturate;
      // R2 R6: both saturating adders at the rails
      p_a[0] = 127;  m_a[0] = -31;
      p_a[1] = -127; m_a[1] = 31;
      p_a[2] = 120;  m_a[2] = 0;
      p_a[3] = 110;  m_a[3] = 0;
      run_row(4, 0, 0, "R2", 1'b0);
      p_a[0] = -128; m_a[0] = 0;
      p_a[1] = -120; m_a[1] = 0;
      p_a[2] = -100; m_a[2] = 0;
      run_row(3, 0, 0, "R6", 1'b0);
   endtask

   task automatic t_ignore;
      // R10: beats during emission are dropped
      fill(6, 9);
      run_row(6, 2, 0, "R10", 1'b1);
      fill(4, 2);
      run_row(4, 0, 0, "R10", 1'b0);
   endtask

   task automatic t_maxdeg;
      // R7: full-degree row
      fill(MAX_DEG, 4);
      run_row(MAX_DEG, 1, 2, "R7", 1'b0);
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_plain();
      t_ties();
      t_offset();
      t_norm();
      t_alt_mode();
      t_saturate();
      t_ignore();
      t_maxdeg();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule